// File: doc/BRIEF.md
# One-Position Combinational Shift Unit Built from Reversible Gates

This block sits between an arithmetic result and an output bus. It passes a word through unchanged, moves it one position right or left, or blocks it by forcing every bit to zero. There is no clock and no register in the path, so the result settles within the same cycle that the destination register captures it. A two-bit select input picks the operation. Two serial inputs supply the bit that enters the word at its top end during a right move and at its bottom end during a left move.

Each output bit comes from its own four-way selector. The selector is assembled only from one-to-one reversible primitives: controlled-swap gates, plus a controlled-XOR gate in the mixed variant. Every gate has as many outputs as inputs, and no output loops back to an input. The two select lines pass through each selector by way of the gates' control outputs and feed the next selector. Any gate output that drives neither a data bit nor another gate leaves the block on a side bus of unused lines, so each gate's full output set can be observed. A parameter picks between two structures: three swap gates per selector with the zero input tied low, or an XOR gate added in front that derives both the zero line and the first data line from one constant line.

Top module: `rshift_unit`

## Requirements
- R1: With sel = 2'b00, dout equals din bit for bit.
- R2: With sel = 2'b01 (sel[0] high), dout[i] = din[i+1] for i below N-1, and dout[N-1] = ser_r.
- R3: With sel = 2'b10 (sel[1] high), dout[i] = din[i-1] for i above 0, and dout[0] = ser_l.
- R4: With sel = 2'b11, every bit of dout is 0 whatever din, ser_r and ser_l hold.
- R5: The two STYLE settings (0 = swap gates only, 1 = mixed) give identical dout and identical junk for every input and select combination.
- R6: junk is 3N+2 bits wide. Its top two bits, junk[3N+1] and junk[3N], carry copies of sel[1] and sel[0] after they pass through every selector.
- R7: The controlled-swap primitive maps (a,b,c) to (a, a?c:b, a?b:c). The map is one-to-one over all 8 input patterns and keeps the count of ones.
- R8: The controlled-XOR primitive maps (a,b) to (a, a^b), and the map is one-to-one over all 4 input patterns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | N | Word to be passed, moved or blocked |
| ser_r | input | 1 | Bit that enters at the top during a right move |
| ser_l | input | 1 | Bit that enters at the bottom during a left move |
| sel | input | 2 | Operation: 00 pass, 01 right, 10 left, 11 zero |
| dout | output | N | Resulting word |
| junk | output | 3N+2 | Unused gate outputs, with the two select copies at the top |

## Verification
The assertions inside the gates and selectors are immediate checks on a combinational network. They rely on every input holding a known 0 or 1, and each one is skipped while any input it reads is unknown. The bench drives every input to a defined level before the first clock edge and never releases one to X or Z. It holds each pattern stable for a full cycle, so each network has settled before the outputs are read. The four-bit instances run through all 256 combinations of data, serial inputs and select. The sixteen-bit instances use random words under all four select values.

// File: rtl/rshift_pkg.sv
package rshift_pkg;
    // Selector structure chosen per instance
    typedef enum logic {
        STYLE_SWAP_ONLY = 1'b0,
        STYLE_MIXED     = 1'b1
    } mux_style_e;

    localparam int JUNK_PER_MUX = 3;
    localparam int SEL_COPIES   = 2;

    function automatic int junk_width(input int nbits);
        return JUNK_PER_MUX * nbits + SEL_COPIES;
    endfunction
endpackage

// File: rtl/rg_feynman.sv
module rg_feynman (
    input  logic a,
    input  logic b,
    output logic p,
    output logic q
);
    assign p = a;
    assign q = a ^ b;

    always_comb begin
        if (!$isunknown({a, b})) begin
            // R8
            xor_undo_chk: assert ((p ^ q) == b && p == a);
        end
    end
endmodule

// File: rtl/rg_fredkin.sv
module rg_fredkin (
    input  logic a,
    input  logic b,
    input  logic c,
    output logic p,
    output logic q,
    output logic r
);
    assign p = a;
    assign q = (~a & b) | (a & c);
    assign r = (a & b) | (~a & c);

    always_comb begin
        if (!$isunknown({a, b, c})) begin
            // R7
            ones_conserve_chk: assert ($countones({a, b, c}) == $countones({p, q, r}));
        end
    end
endmodule

// File: rtl/rg_mux4.sv
module rg_mux4
    import rshift_pkg::*;
#(
    parameter mux_style_e STYLE = STYLE_SWAP_ONLY
) (
    input  logic       lo_i,
    input  logic       hi_i,
    input  logic       d0_i,
    input  logic       d1_i,
    input  logic       d2_i,
    input  logic       zero_i,
    output logic       y_o,
    output logic       lo_o,
    output logic       hi_o,
    output logic [2:0] junk_o
);
    logic first_d, zero_d;
    logic lo_mid_d;
    logic lowpair_d, highpair_d;

    generate
        if (STYLE == STYLE_MIXED) begin : g_mixed
            // constant line is the control; data passes, constant is copied out
            rg_feynman u_copy (
                .a (zero_i),
                .b (d0_i),
                .p (zero_d),
                .q (first_d)
            );
        end else begin : g_swap
            assign zero_d  = zero_i;
            assign first_d = d0_i;
        end
    endgenerate

    rg_fredkin u_low (
        .a (lo_i), .b (first_d), .c (d1_i),
        .p (lo_mid_d), .q (lowpair_d), .r (junk_o[0])
    );

    rg_fredkin u_high (
        .a (lo_mid_d), .b (d2_i), .c (zero_d),
        .p (lo_o), .q (highpair_d), .r (junk_o[1])
    );

    rg_fredkin u_final (
        .a (hi_i), .b (lowpair_d), .c (highpair_d),
        .p (hi_o), .q (y_o), .r (junk_o[2])
    );

    always_comb begin
        if (!$isunknown({hi_i, lo_i, d0_i, d1_i, d2_i, zero_i})) begin
            // R1
            pass_route_chk: assert ({hi_i, lo_i} != 2'b00 || y_o == d0_i);
            // R2
            right_route_chk: assert ({hi_i, lo_i} != 2'b01 || y_o == d1_i);
            // R3
            left_route_chk: assert ({hi_i, lo_i} != 2'b10 || y_o == d2_i);
            // R6
            sel_thru_chk: assert (lo_o == lo_i && hi_o == hi_i);
        end
    end
endmodule

// File: rtl/rshift_unit.sv
module rshift_unit
    import rshift_pkg::*;
#(
    parameter int         N     = 4,
    parameter mux_style_e STYLE = STYLE_SWAP_ONLY,
    localparam int        JW    = junk_width(N)
) (
    input  logic [N-1:0]  din,
    input  logic          ser_r,
    input  logic          ser_l,
    input  logic [1:0]    sel,
    output logic [N-1:0]  dout,
    output logic [JW-1:0] junk
);
    logic [N:0] lo_chain;
    logic [N:0] hi_chain;

    assign lo_chain[0] = sel[0];
    assign hi_chain[0] = sel[1];

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic from_above, from_below;
        if (i == N - 1) begin : g_top
            assign from_above = ser_r;
        end else begin : g_inner_hi
            assign from_above = din[i+1];
        end
        if (i == 0) begin : g_bot
            assign from_below = ser_l;
        end else begin : g_inner_lo
            assign from_below = din[i-1];
        end

        rg_mux4 #(.STYLE(STYLE)) u_mux (
            .lo_i   (lo_chain[i]),
            .hi_i   (hi_chain[i]),
            .d0_i   (din[i]),
            .d1_i   (from_above),
            .d2_i   (from_below),
            .zero_i (1'b0),
            .y_o    (dout[i]),
            .lo_o   (lo_chain[i+1]),
            .hi_o   (hi_chain[i+1]),
            .junk_o (junk[3*i+2:3*i])
        );
    end

    assign junk[JW-2] = lo_chain[N];
    assign junk[JW-1] = hi_chain[N];

    always_comb begin
        if (!$isunknown({sel, din, ser_r, ser_l})) begin
            // R4
            block_zero_chk: assert (sel != 2'b11 || dout == '0);
        end
    end
endmodule

// File: tb/tb_rshift_unit.sv
module tb_rshift_unit;
    import rshift_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NW = 16;
    localparam int JS = 3 * NS + 2;
    localparam int JWW = 3 * NW + 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [NS-1:0] s_din = '0;
    logic          s_r = 1'b0, s_l = 1'b0;
    logic [1:0]    s_sel = 2'b00;
    logic [NS-1:0] s_out_a, s_out_b;
    logic [JS-1:0] s_junk_a, s_junk_b;

    logic [NW-1:0] w_din = '0;
    logic          w_r = 1'b0, w_l = 1'b0;
    logic [1:0]    w_sel = 2'b00;
    logic [NW-1:0] w_out_a, w_out_b;
    logic [JWW-1:0] w_junk_a, w_junk_b;

    logic fa = 1'b0, fb = 1'b0, fc = 1'b0, fp, fq, fr;
    logic xa = 1'b0, xb = 1'b0, xp, xq;

    rshift_unit #(.N(NS), .STYLE(STYLE_SWAP_ONLY)) dut (
        .din(s_din), .ser_r(s_r), .ser_l(s_l), .sel(s_sel), .dout(s_out_a), .junk(s_junk_a));
    rshift_unit #(.N(NS), .STYLE(STYLE_MIXED)) dut_mx (
        .din(s_din), .ser_r(s_r), .ser_l(s_l), .sel(s_sel), .dout(s_out_b), .junk(s_junk_b));
    rshift_unit #(.N(NW), .STYLE(STYLE_SWAP_ONLY)) dut_w (
        .din(w_din), .ser_r(w_r), .ser_l(w_l), .sel(w_sel), .dout(w_out_a), .junk(w_junk_a));
    rshift_unit #(.N(NW), .STYLE(STYLE_MIXED)) dut_wm (
        .din(w_din), .ser_r(w_r), .ser_l(w_l), .sel(w_sel), .dout(w_out_b), .junk(w_junk_b));

    rg_fredkin u_fk (.a(fa), .b(fb), .c(fc), .p(fp), .q(fq), .r(fr));
    rg_feynman u_fy (.a(xa), .b(xb), .p(xp), .q(xq));

    function automatic logic [63:0] model(input logic [63:0] d, input int n,
                                          input logic ir, input logic il, input logic [1:0] s);
        logic [63:0] m;
        m = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
        case (s)
            2'b00: return d & m;
            2'b01: return ((d & m) >> 1) | ({63'd0, ir} << (n - 1));
            2'b10: return ((d << 1) & m) | {63'd0, il};
            default: return 64'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string req_of(input logic [1:0] s);
        case (s)
            2'b00: return "R1";
            2'b01: return "R2";
            2'b10: return "R3";
            default: return "R4";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        // idle state after reset: zero word passed
        check("R1 idle", {60'd0, s_out_a}, 64'd0);

        // R7: swap primitive, mapping, one-to-one, ones kept
        begin
            bit [7:0] seen = '0;
            for (int v = 0; v < 8; v++) begin
                @(posedge clk);
                {fa, fb, fc} = v[2:0];
                @(negedge clk);
                check("R7 map", {61'd0, fp, fq, fr},
                      {61'd0, fa, (fa ? fc : fb), (fa ? fb : fc)});
                check("R7 unique", {63'd0, seen[{fp, fq, fr}]}, 64'd0);
                check("R7 ones", $countones({fp, fq, fr}), $countones(v[2:0]));
                seen[{fp, fq, fr}] = 1'b1;
            end
        end

        // R8: xor primitive
        begin
            bit [3:0] seen = '0;
            for (int v = 0; v < 4; v++) begin
                @(posedge clk);
                {xa, xb} = v[1:0];
                @(negedge clk);
                check("R8 map", {62'd0, xp, xq}, {62'd0, xa, xa ^ xb});
                check("R8 unique", {63'd0, seen[{xp, xq}]}, 64'd0);
                seen[{xp, xq}] = 1'b1;
            end
        end

        // Exhaustive 4-bit sweep
        for (int v = 0; v < 256; v++) begin
            @(posedge clk);
            s_din = v[3:0];
            s_r   = v[4];
            s_l   = v[5];
            s_sel = v[7:6];
            @(negedge clk);
            check(req_of(s_sel), {60'd0, s_out_a}, model({60'd0, s_din}, NS, s_r, s_l, s_sel));
            check("R5 dout", {60'd0, s_out_b}, {60'd0, s_out_a});
            check("R5 junk", {50'd0, s_junk_b}, {50'd0, s_junk_a});
            check("R6 sel copy", {62'd0, s_junk_a[JS-1], s_junk_a[JS-2]}, {62'd0, s_sel});
        end

        // Random 16-bit patterns under every select value
        for (int k = 0; k < 400; k++) begin
            @(posedge clk);
            w_din = NW'($urandom);
            w_r   = 1'($urandom);
            w_l   = 1'($urandom);
            w_sel = 2'(k % 4);
            @(negedge clk);
            check(req_of(w_sel), {48'd0, w_out_a}, model({48'd0, w_din}, NW, w_r, w_l, w_sel));
            check("R5 wide", {48'd0, w_out_b}, {48'd0, w_out_a});
            check("R6 wide", {62'd0, w_junk_b[JWW-1], w_junk_b[JWW-2]}, {62'd0, w_sel});
        end

        // Boundary: all ones with serial bits low, then high
        for (int s = 0; s < 4; s++) begin
            for (int b = 0; b < 2; b++) begin
                @(posedge clk);
                w_din = '1;
                w_r = b[0];
                w_l = b[0];
                w_sel = 2'(s);
                @(negedge clk);
                check(req_of(w_sel), {48'd0, w_out_a}, model({48'd0, w_din}, NW, w_r, w_l, w_sel));
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule